// File: doc/BRIEF.md
# Per-Timer Clock Rate Selector

This block produces the count-enable strobes for a group of timers. Each timer advances at one of two rates. The legacy rate gives one strobe every 12 input clocks. The fast rate gives one strobe every 4 input clocks.

A single control register selects the rate for each timer. Software writes it over a simple address/data write port. The register's full contents are always presented on a read-data output.

A single free-running twelve-phase counter serves every timer. Because the fast strobe is taken from phases 0, 4 and 8 of that counter, the two rates stay locked together. Each timer therefore only chooses which of two shared enables it registers onto its strobe. Reset is asserted asynchronously and released through a small synchronizer. After reset, every timer runs at the legacy rate.

Top module: `tick_rate_sel`

## Requirements
- R1: While `rst_n` is low, every `tick` bit is 0 and `cfg_rdata` reads 0x00. After release, the first strobe appears on all timers together after the third rising clock edge, and every timer then runs at the 12-clock rate.
- R2: While a timer's select bit is 1, that timer's strobe occurs exactly once every 4 clock cycles.
- R3: While a timer's select bit is 0, that timer's strobe occurs exactly once every 12 clock cycles.
- R4: The control register is at address 0x8E. Bit 3 selects the rate of `tick[0]`, bit 4 selects `tick[1]` and bit 5 selects `tick[2]` (1 = fast, 0 = legacy).
- R5: Writing the select bit of one timer never changes the strobe timing of any other timer.
- R6: Every strobe a timer produces at the legacy rate falls in the same cycle as a strobe on every other timer.
- R7: A new select value takes effect at the next boundary of the newly chosen rate. The spacing between two consecutive strobes of one timer is always 4, 8 or 12 cycles, never any other value.
- R8: A write to any address other than 0x8E leaves the register and all strobe timing unchanged.
- R9: All 8 bits written to 0x8E are stored and appear on `cfg_rdata` one cycle after the write. Bits other than 3 to 5 have no effect on the strobes.
- R10: Each strobe is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that all rates are divided from |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Current contents of the rate control register |
| tick | output | 3 | One-cycle count-enable strobe per timer |

## Verification
Two events can land in the same cycle:
- a write that flips a select bit, and
- a boundary of the shared twelve-phase counter, where a legacy strobe and a fast strobe coincide at phase 0.

The bench provokes this with a long run of rate writes at spacings that walk through every phase offset. Meanwhile a second timer is held at a fixed rate while its neighbours' bits toggle. A behavioural model predicts every strobe and the register value on every cycle. A gap monitor confirms that no timer ever sees a strobe spacing other than 4, 8 or 12 cycles.

// File: rtl/tick_rate_pkg.sv
package tick_rate_pkg;
  // Rate choice carried by one select bit.
  typedef enum logic {
    RATE_LEGACY = 1'b0,
    RATE_FAST   = 1'b1
  } rate_e;

  // Default location of the rate control register in the special-function space.
  localparam logic [7:0] CTRL_ADDR_DEFAULT = 8'h8E;
endpackage

// File: rtl/trs_reset_sync.sv
module trs_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = (sync_q << 1) | STAGES'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/trs_phase_gen.sv
module trs_phase_gen #(
  parameter int unsigned DIV_SLOW = 12,
  parameter int unsigned DIV_FAST = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic slow_hit,
  output logic fast_hit
);
  localparam int unsigned PH_W  = $clog2(DIV_SLOW);
  localparam int unsigned SUB_W = $clog2(DIV_FAST);

  logic [PH_W-1:0]  phase_q, phase_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             phase_wrap, sub_wrap;

  // Both counters start at zero and DIV_SLOW is a multiple of DIV_FAST,
  // so the fast sub-phase is zero exactly at phases 0, DIV_FAST, 2*DIV_FAST ...
  always_comb begin
    phase_wrap = (phase_q == PH_W'(DIV_SLOW - 1));
    sub_wrap   = (sub_q == SUB_W'(DIV_FAST - 1));
    phase_d    = phase_wrap ? '0 : phase_q + PH_W'(1);
    sub_d      = sub_wrap   ? '0 : sub_q + SUB_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      sub_q   <= '0;
    end else begin
      phase_q <= phase_d;
      sub_q   <= sub_d;
    end
  end

  assign slow_hit = (phase_q == '0);
  assign fast_hit = (sub_q == '0);
endmodule

// File: rtl/trs_ctrl_reg.sv
module trs_ctrl_reg #(
  parameter int unsigned       ADDR_W = 8,
  parameter int unsigned       DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR   = 8'h8E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_q, q_d;
  logic              hit;

  always_comb begin
    hit = we && (addr == ADDR);
    q_d = q_q;
    if (hit) begin
      q_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (hit) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;
endmodule

// File: rtl/trs_tick_sel.sv
module trs_tick_sel
  import tick_rate_pkg::*;
#(
  parameter int unsigned NUM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] sel,
  input  logic           slow_hit,
  input  logic           fast_hit,
  output logic [NUM-1:0] tick
);
  logic [NUM-1:0] tick_q, tick_d;

  for (genvar g = 0; g < NUM; g++) begin : g_lane
    rate_e rate;
    assign rate = rate_e'(sel[g]);
    always_comb begin
      tick_d[g] = (rate == RATE_FAST) ? fast_hit : slow_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/tick_rate_sel.sv
module tick_rate_sel #(
  parameter int unsigned       NUM_TIMERS = 3,
  parameter int unsigned       SEL_LSB    = 3,
  parameter int unsigned       DIV_SLOW   = 12,
  parameter int unsigned       DIV_FAST   = 4,
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = tick_rate_pkg::CTRL_ADDR_DEFAULT,
  parameter int unsigned       RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [DATA_W-1:0]     cfg_rdata,
  output logic [NUM_TIMERS-1:0] tick
);
  logic                  rst_int_n;
  logic                  slow_hit;
  logic                  fast_hit;
  logic [DATA_W-1:0]     ctrl_q;
  logic [NUM_TIMERS-1:0] sel;

  trs_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  trs_phase_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_phase (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .slow_hit (slow_hit),
    .fast_hit (fast_hit)
  );

  trs_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR(CTRL_ADDR)) u_reg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .q     (ctrl_q)
  );

  assign sel       = ctrl_q[SEL_LSB +: NUM_TIMERS];
  assign cfg_rdata = ctrl_q;

  trs_tick_sel #(.NUM(NUM_TIMERS)) u_sel (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel      (sel),
    .slow_hit (slow_hit),
    .fast_hit (fast_hit),
    .tick     (tick)
  );
endmodule

// File: rtl/tick_rate_sel_chk.sv
module tick_rate_sel_chk #(
  parameter int unsigned       NUM_TIMERS = 3,
  parameter int unsigned       SEL_LSB    = 3,
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h8E,
  parameter int unsigned       RST_STAGES = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [ADDR_W-1:0]     cfg_addr,
  input logic [DATA_W-1:0]     cfg_wdata,
  input logic [DATA_W-1:0]     cfg_rdata,
  input logic [NUM_TIMERS-1:0] tick
);
  // Counts edges since reset release, so that writes are judged only once the
  // internal reset has let go.
  logic [3:0] rel_cnt;
  logic       ready;
  assign ready = (rel_cnt >= 4'(RST_STAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt <= '0;
    end else if (!ready) begin
      rel_cnt <= rel_cnt + 4'd1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (tick == '0 && cfg_rdata == '0));

  p_foreign_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr != CTRL_ADDR) |=> $stable(cfg_rdata));

  p_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cfg_we && cfg_addr == CTRL_ADDR) |=> (cfg_rdata == $past(cfg_wdata)));

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_t
    p_fast_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick[g], 4) && $past(cfg_rdata[SEL_LSB+g])) |-> tick[g]);

    p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[g] && !$past(cfg_rdata[SEL_LSB+g])) |-> (&tick));

    p_min_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick[g] |-> (!$past(tick[g], 2) && !$past(tick[g], 3)));

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tick[g] |=> !tick[g]);
  end
endmodule

bind tick_rate_sel tick_rate_sel_chk #(
  .NUM_TIMERS (NUM_TIMERS),
  .SEL_LSB    (SEL_LSB),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .CTRL_ADDR  (CTRL_ADDR),
  .RST_STAGES (RST_STAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .tick      (tick)
);

// File: tb/tick_rate_sel_bench.sv
`timescale 1ns/1ps
module tick_rate_sel_bench;
  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic [2:0] tick;

  int    n_checks;
  int    n_fail;
  string cur_req;
  bit    cmp_en;
  bit    done;

  tick_rate_sel u_tick_rate_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tick      (tick)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference: integer phase, delayed start after reset.
  int         m_rel;
  int         m_ph;
  logic [7:0] m_reg;
  logic [2:0] m_tick;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel  = 0;
      m_ph   = 0;
      m_reg  = 8'h00;
      m_tick = 3'b000;
    end else if (m_rel < 2) begin
      m_rel  = m_rel + 1;
      m_tick = 3'b000;
    end else begin
      for (int i = 0; i < 3; i++) begin
        m_tick[i] = m_reg[3+i] ? ((m_ph % 4) == 0) : (m_ph == 0);
      end
      m_ph = (m_ph + 1) % 12;
      if (cfg_we && cfg_addr == 8'h8E) m_reg = cfg_wdata;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison and gap monitor.
  int cyc;
  int last_tk[3];
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) last_tk[i] = -1;
    end
    if (cmp_en) begin
      check(cur_req, "tick vs model", int'(tick), int'(m_tick));
      check(cur_req, "rdata vs model", int'(cfg_rdata), int'(m_reg));
      for (int i = 0; i < 3; i++) begin
        if (tick[i] === 1'b1) begin
          if (last_tk[i] >= 0) begin
            // R7: spacing is 4, 8 or 12
            check("R7", "gap legal", int'((cyc - last_tk[i]) % 4 == 0 &&
                  (cyc - last_tk[i]) >= 4 && (cyc - last_tk[i]) <= 12), 1);
          end
          last_tk[i] = cyc;
        end
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic count_win(int n, output int c0, output int c1, output int c2);
    c0 = 0; c1 = 0; c2 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      c0 += int'(tick[0]);
      c1 += int'(tick[1]);
      c2 += int'(tick[2]);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int c0, c1, c2;
    int width_ok;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 8'h00; cfg_wdata = 8'h00;
    cur_req = "R1";
    repeat (5) @(negedge clk);
    check("R1", "tick in reset", int'(tick), 0);
    check("R1", "rdata in reset", int'(cfg_rdata), 0);
    cmp_en = 1'b1;
    rst_n  = 1'b1;
    // First strobe after the third rising edge, all timers together.
    repeat (2) @(negedge clk);
    check("R1", "no tick before third edge", int'(tick), 0);
    @(negedge clk);
    check("R1", "first tick on all timers", int'(tick), 7);
    count_win(48, c0, c1, c2);
    check("R3", "t0 legacy count", c0, 4);
    check("R3", "t1 legacy count", c1, 4);
    check("R3", "t2 legacy count", c2, 4);

    // R4 mapping, R2 fast rate, R5 others unchanged.
    cur_req = "R4";
    wr(8'h8E, 8'h08); repeat (12) @(negedge clk);
    count_win(48, c0, c1, c2);
    check("R2", "bit3 fast t0", c0, 12);
    check("R5", "t1 unaffected", c1, 4);
    check("R5", "t2 unaffected", c2, 4);
    wr(8'h8E, 8'h10); repeat (12) @(negedge clk);
    count_win(48, c0, c1, c2);
    check("R4", "bit4 fast t1", c1, 12);
    check("R4", "t0 back to legacy", c0, 4);
    wr(8'h8E, 8'h20); repeat (12) @(negedge clk);
    count_win(48, c0, c1, c2);
    check("R4", "bit5 fast t2", c2, 12);
    check("R4", "t1 back to legacy", c1, 4);

    // R8: foreign addresses ignored.
    cur_req = "R8";
    wr(8'h8F, 8'hFF);
    wr(8'h0E, 8'h18);
    check("R8", "rdata after foreign writes", int'(cfg_rdata), 8'h20);
    count_win(48, c0, c1, c2);
    check("R8", "t0 still legacy", c0, 4);
    check("R8", "t2 still fast", c2, 12);

    // R9: unused bits stored, no effect.
    cur_req = "R9";
    wr(8'h8E, 8'hC7);
    check("R9", "readback", int'(cfg_rdata), 8'hC7);
    repeat (12) @(negedge clk);
    count_win(48, c0, c1, c2);
    check("R9", "t0 legacy with other bits", c0, 4);
    check("R9", "t1 legacy with other bits", c1, 4);
    check("R9", "t2 legacy with other bits", c2, 4);

    // R5: t1 held fast while neighbours toggle.
    cur_req = "R5";
    wr(8'h8E, 8'h10); repeat (12) @(negedge clk);
    fork
      begin
        for (int k = 0; k < 10; k++) begin
          repeat (k % 5) @(negedge clk);
          wr(8'h8E, (k % 2) ? 8'h38 : 8'h10);
        end
      end
      count_win(48, c0, c1, c2);
    join
    check("R5", "t1 steady while others toggle", c1, 12);

    // R7 / R6: writes at every phase offset.
    cur_req = "R7";
    for (int k = 0; k < 30; k++) begin
      repeat (k % 13) @(negedge clk);
      wr(8'h8E, 8'((k * 37 + 5) & 8'h38));
    end
    repeat (24) @(negedge clk);

    // R10: strobe width over a fast window.
    cur_req = "R10";
    wr(8'h8E, 8'h38); repeat (12) @(negedge clk);
    width_ok = 1;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (tick[0] && tick == 3'b111) begin
        @(negedge clk);
        if (tick != 3'b000) width_ok = 0;
      end
    end
    check("R10", "one-cycle strobe", width_ok, 1);

    // R1: asynchronous reset mid-run.
    cur_req = "R1";
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    check("R1", "tick after async reset", int'(tick), 0);
    check("R1", "rdata after async reset", int'(cfg_rdata), 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "restart tick", int'(tick), 7);
    repeat (20) @(negedge clk);
    summary();
  end
endmodule